// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Detector

This block recognises a dual-tone signalling digit by counting clock cycles. It receives two single-bit square waves. One comes from the comparator of the low band and one from the comparator of the high band. Band splitting and slicing happen upstream, so the inputs are clean logic levels. Each band has its own meter. The meter counts system-clock cycles between consecutive transitions of its input, which gives a half-period measurement. It then compares that count against four half-period windows, one for each nominal tone of the band.

The windows are computed at elaboration from the clock frequency parameter (3.579545 MHz by default) and a tolerance given in per mille. A band is reported present only after two back-to-back half-periods land in the same window. The top registers a row index from the low band and a column index from the high band. It also registers a flag that is high while both bands are present at once. An inhibit input hides the highest column tone. A power-down input clears the whole detector and holds it idle.

Top module: `dtmf_pair_detect`

## Requirements
- R1: After reset, `pair_o` is 0 and both `row_o` and `col_o` are 0.
- R2: The low band tones 697, 770, 852 and 941 Hz are reported on `row_o` as 0, 1, 2 and 3 respectively.
- R3: The high band tones 1209, 1336, 1477 and 1633 Hz are reported on `col_o` as 0, 1, 2 and 3 respectively.
- R4: A tone whose frequency is off nominal by no more than 1.5 % is accepted and reported with the index of that nominal tone.
- R5: A tone that is 3.5 % or more away from every nominal tone of its band never makes that band present.
- R6: A band becomes present only when two consecutive half-period measurements fall in the same window. A signal whose half-periods alternate between two different windows never makes the band present.
- R7: `pair_o` is 1 only while both bands are present together. A tone in a single band keeps `pair_o` at 0.
- R8: While `inh_i` is 1, the 1633 Hz high tone (column 3) is never reported as present. A tone pair that is already present with column 3 drops out within one half-period plus the pipeline delay. The other columns are unaffected.
- R9: While `pwr_dn_i` is 1, all detection state is cleared. From the second rising edge after `pwr_dn_i` is sampled high, `pair_o`, `row_o` and `col_o` read 0. After release, detection resumes normally.
- R10: When a band stops toggling, its presence is withdrawn once no transition has been seen for longer than the longest accepted half-period. `pair_o` then falls, while `row_o` and `col_o` keep the last digit reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency given by CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| pwr_dn_i | input | 1 | Power-down, active high; clears and idles the detector |
| low_sq_i | input | 1 | Squared low-band signal (asynchronous, synchronised inside) |
| high_sq_i | input | 1 | Squared high-band signal (asynchronous, synchronised inside) |
| inh_i | input | 1 | When high, column 3 (1633 Hz) is suppressed |
| row_o | output | 2 | Row index of the last detected pair |
| col_o | output | 2 | Column index of the last detected pair |
| pair_o | output | 1 | High while both bands hold a valid tone |

## Verification
The stimulus covers every nominal row and column. It adds tones placed 1 % off nominal, which must still be accepted, and tones placed 5 % off, which a window sized too wide would wrongly accept. A high band whose half-periods alternate between two column windows checks the confirmation rule; a detector that trusted a single measurement would raise the pair flag there. Silence after each digit shows whether the presence timeout works and whether the row and column hold their last values; a missing timeout would leave `pair_o` stuck high. Separate cases cover inhibit, both held from the start and raised during a live 1633 Hz tone, and power-down in the middle of a detected pair. A wrong mask or an unclear path would leave column 3 or the stale digit visible.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  typedef logic [1:0] tone_idx_t;

  // Nominal tone frequencies in Hz; the index is the reported row/column.
  function automatic int nom_hz(input bit high_band, input int idx);
    int f;
    if (high_band) begin
      case (idx)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end else begin
      case (idx)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end
    return f;
  endfunction

  // Shortest accepted half-period: tone raised by the tolerance, rounded down.
  function automatic int win_lo(input longint clk_hz, input int f, input int tol_pm);
    longint num;
    longint den;
    num = clk_hz * 64'sd1000;
    den = 64'(2 * f * (1000 + tol_pm));
    return int'(num / den);
  endfunction

  // Longest accepted half-period: tone lowered by the tolerance, rounded up.
  function automatic int win_hi(input longint clk_hz, input int f, input int tol_pm);
    longint num;
    longint den;
    num = clk_hz * 64'sd1000;
    den = 64'(2 * f * (1000 - tol_pm));
    return int'((num + den - 64'sd1) / den);
  endfunction

endpackage

// File: rtl/tone_meter.sv
module tone_meter
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ   = 3579545,
  parameter int TOL_PM   = 15,
  parameter bit HIGH_GRP = 1'b0
) (
  input  logic      clk,
  input  logic      clr,
  input  logic      sq_i,
  input  logic      dis_top_i,
  output logic      valid_o,
  output tone_idx_t idx_o
);

  localparam int NTONE = 4;
  // Index 0 is the lowest frequency, so it has the longest half-period.
  localparam int LIMIT = win_hi(longint'(CLK_HZ), nom_hz(HIGH_GRP, 0), TOL_PM) + 2;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LIMIT);

  logic [1:0]       sync_q;
  logic             prev_q;
  logic             edge_w;
  logic [CNT_W-1:0] cnt_q;
  logic [NTONE-1:0] in_win;
  logic             hit_w;
  tone_idx_t        cls_w;
  logic             last_hit_q;
  tone_idx_t        last_idx_q;

  assign edge_w = sync_q[1] ^ prev_q;

  // One half-period window per nominal tone; the top tone can be masked.
  for (genvar g = 0; g < NTONE; g++) begin : g_win
    localparam logic [CNT_W-1:0] LO =
      CNT_W'(win_lo(longint'(CLK_HZ), nom_hz(HIGH_GRP, g), TOL_PM));
    localparam logic [CNT_W-1:0] HI =
      CNT_W'(win_hi(longint'(CLK_HZ), nom_hz(HIGH_GRP, g), TOL_PM));
    if (g == NTONE - 1) begin : g_mask
      assign in_win[g] = (cnt_q >= LO) && (cnt_q <= HI) && !dis_top_i;
    end else begin : g_plain
      assign in_win[g] = (cnt_q >= LO) && (cnt_q <= HI);
    end
  end

  always_comb begin
    hit_w = 1'b0;
    cls_w = '0;
    for (int k = NTONE - 1; k >= 0; k--) begin
      if (in_win[k]) begin
        hit_w = 1'b1;
        cls_w = tone_idx_t'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      sync_q     <= '0;
      prev_q     <= 1'b0;
      cnt_q      <= CNT_SAT;
      last_hit_q <= 1'b0;
      last_idx_q <= '0;
      valid_o    <= 1'b0;
      idx_o      <= '0;
    end else begin
      sync_q <= {sync_q[0], sq_i};
      prev_q <= sync_q[1];
      if (edge_w) begin
        cnt_q      <= CNT_W'(1);
        last_hit_q <= hit_w;
        last_idx_q <= cls_w;
        if (hit_w && last_hit_q && (cls_w == last_idx_q)) begin
          valid_o <= 1'b1;
          idx_o   <= cls_w;
        end else begin
          valid_o <= 1'b0;
        end
      end else if (cnt_q != CNT_SAT) begin
        cnt_q <= cnt_q + 1'b1;
        if (dis_top_i && (idx_o == tone_idx_t'(NTONE - 1))) valid_o <= 1'b0;
      end else begin
        valid_o    <= 1'b0;
        last_hit_q <= 1'b0;
      end
    end
  end

  // Presence can only start on a transition that completed a measurement.
  assert_confirm_on_edge_R6: assert property (@(posedge clk) disable iff (clr)
    $rose(valid_o) |-> $past(edge_w));

  // A masked top tone is never left standing.
  assert_inhibit_top_R8: assert property (@(posedge clk) disable iff (clr)
    dis_top_i |=> !(valid_o && (idx_o == tone_idx_t'(NTONE - 1))));

  // Silence longer than the longest window withdraws presence.
  assert_silence_drop_R10: assert property (@(posedge clk) disable iff (clr)
    ((cnt_q == CNT_SAT) && !edge_w) |=> !valid_o);

endmodule

// File: rtl/dtmf_pair_detect.sv
module dtmf_pair_detect
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ = 3579545,
  parameter int TOL_PM = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_dn_i,
  input  logic       low_sq_i,
  input  logic       high_sq_i,
  input  logic       inh_i,
  output logic [1:0] row_o,
  output logic [1:0] col_o,
  output logic       pair_o
);

  logic      clr;
  logic      low_vld;
  logic      high_vld;
  tone_idx_t low_idx;
  tone_idx_t high_idx;

  assign clr = rst | pwr_dn_i;

  tone_meter #(.CLK_HZ(CLK_HZ), .TOL_PM(TOL_PM), .HIGH_GRP(1'b0)) low_meter_i (
    .clk       (clk),
    .clr       (clr),
    .sq_i      (low_sq_i),
    .dis_top_i (1'b0),
    .valid_o   (low_vld),
    .idx_o     (low_idx)
  );

  tone_meter #(.CLK_HZ(CLK_HZ), .TOL_PM(TOL_PM), .HIGH_GRP(1'b1)) high_meter_i (
    .clk       (clk),
    .clr       (clr),
    .sq_i      (high_sq_i),
    .dis_top_i (inh_i),
    .valid_o   (high_vld),
    .idx_o     (high_idx)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      pair_o <= 1'b0;
      row_o  <= '0;
      col_o  <= '0;
    end else begin
      pair_o <= low_vld & high_vld;
      if (low_vld && high_vld) begin
        row_o <= low_idx;
        col_o <= high_idx;
      end
    end
  end

  // The pair flag follows joint presence of both bands.
  assert_pair_needs_both_R7: assert property (@(posedge clk) disable iff (rst)
    pair_o |-> $past(low_vld && high_vld));

  // Power-down clears every output on the following edge.
  assert_pwrdn_clears_R9: assert property (@(posedge clk) disable iff (rst)
    pwr_dn_i |=> (!pair_o && (row_o == 2'd0) && (col_o == 2'd0)));

endmodule

// File: tb/dtmf_pair_detect_tb_top.sv
`timescale 1ns/1ps
module dtmf_pair_detect_tb_top;

  localparam int CLK_HZ = 1789772;
  localparam int SETTLE = 5000;
  localparam int QUIET  = 1500;
  localparam int NVEC   = 12;

  typedef struct packed {
    int lo;   // row index, -1 = silent
    int lod;  // low deviation, per mille (positive = higher freq)
    int hi;   // column index, -1 = silent
    int hid;  // high deviation, per mille
    int inh;
    int pr;   // expected pair flag
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{0, 0, 0, 0, 0, 1},
    '{1, 0, 1, 0, 0, 1},
    '{2, 0, 2, 0, 0, 1},
    '{3, 0, 3, 0, 0, 1},
    '{0, 10, 3, -10, 0, 1},
    '{3, -10, 1, 10, 0, 1},
    '{2, 50, 0, 0, 0, 0},
    '{1, 0, 2, -50, 0, 0},
    '{0, 0, 3, 0, 1, 0},
    '{2, 0, 1, 0, 1, 1},
    '{1, 0, -1, 0, 0, 0},
    '{-1, 0, 2, 0, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dn = 1'b0;
  logic low_sq = 1'b0;
  logic high_sq = 1'b0;
  logic inh = 1'b0;
  logic [1:0] row;
  logic [1:0] col;
  logic pair;

  int n_chk = 0;
  int n_fail = 0;
  int lo_a = 0, lo_b = 0, hi_a = 0, hi_b = 0;
  int lo_cnt = 0, hi_cnt = 0;
  int exp_row = 0, exp_col = 0;

  always #2.5 clk = ~clk;

  dtmf_pair_detect #(.CLK_HZ(CLK_HZ), .TOL_PM(15)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .pwr_dn_i  (pwr_dn),
    .low_sq_i  (low_sq),
    .high_sq_i (high_sq),
    .inh_i     (inh),
    .row_o     (row),
    .col_o     (col),
    .pair_o    (pair)
  );

  // Square-wave generators: half-period a while low, b while high; 0 = silent.
  always @(negedge clk) begin
    if (lo_a == 0) begin
      low_sq <= 1'b0; lo_cnt <= 0;
    end else if (lo_cnt >= ((low_sq ? lo_b : lo_a) - 1)) begin
      low_sq <= ~low_sq; lo_cnt <= 0;
    end else lo_cnt <= lo_cnt + 1;
    if (hi_a == 0) begin
      high_sq <= 1'b0; hi_cnt <= 0;
    end else if (hi_cnt >= ((high_sq ? hi_b : hi_a) - 1)) begin
      high_sq <= ~high_sq; hi_cnt <= 0;
    end else hi_cnt <= hi_cnt + 1;
  end

  function automatic int half_of(input bit hb, input int i, input int dev);
    int f;
    longint num, den;
    if (i < 0) return 0;
    case ({hb, 2'(i)})
      3'b000: f = 697;  3'b001: f = 770;  3'b010: f = 852;  3'b011: f = 941;
      3'b100: f = 1209; 3'b101: f = 1336; 3'b110: f = 1477; default: f = 1633;
    endcase
    num = longint'(CLK_HZ) * 1000;
    den = longint'(2 * f * (1000 + dev));
    return int'(num / den);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tones(input int l, input int ld, input int h, input int hd);
    lo_a = half_of(1'b0, l, ld); lo_b = lo_a;
    hi_a = half_of(1'b1, h, hd); hi_b = hi_a;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wait_cyc(2);
    check("R1 pair", int'(pair), 0);
    check("R1 row", int'(row), 0);
    check("R1 col", int'(col), 0);

    // Vector table: R2 R3 R4 R5 R7 R8, with R10 checked after each entry.
    for (int v = 0; v < NVEC; v++) begin
      inh = VECS[v].inh[0];
      tones(VECS[v].lo, VECS[v].lod, VECS[v].hi, VECS[v].hid);
      wait_cyc(SETTLE);
      if (VECS[v].pr != 0) begin
        exp_row = VECS[v].lo;
        exp_col = VECS[v].hi;
      end
      check($sformatf("R2/R3/R4/R5/R7/R8 vec %0d pair", v), int'(pair), VECS[v].pr);
      check($sformatf("R2 vec %0d row", v), int'(row), exp_row);
      check($sformatf("R3 vec %0d col", v), int'(col), exp_col);
      tones(-1, 0, -1, 0);
      wait_cyc(QUIET);
      check($sformatf("R10 vec %0d pair after silence", v), int'(pair), 0);
      check($sformatf("R10 vec %0d row held", v), int'(row), exp_row);
      check($sformatf("R10 vec %0d col held", v), int'(col), exp_col);
      inh = 1'b0;
    end

    // R6: high half-periods alternate between the 1209 and 1336 windows.
    lo_a = half_of(1'b0, 0, 0); lo_b = lo_a;
    hi_a = half_of(1'b1, 0, 0); hi_b = half_of(1'b1, 1, 0);
    wait_cyc(SETTLE);
    check("R6 alternating windows pair", int'(pair), 0);
    tones(-1, 0, -1, 0);
    wait_cyc(QUIET);

    // R8: inhibit raised while a 1633 Hz pair is present.
    tones(2, 0, 3, 0);
    wait_cyc(SETTLE);
    check("R8 pre-inhibit pair", int'(pair), 1);
    check("R8 pre-inhibit col", int'(col), 3);
    inh = 1'b1;
    wait_cyc(1000);
    check("R8 inhibit mid-tone pair", int'(pair), 0);
    inh = 1'b0;
    tones(-1, 0, -1, 0);
    wait_cyc(QUIET);

    // R9: power-down during a present pair, then recovery.
    tones(1, 0, 1, 0);
    wait_cyc(SETTLE);
    check("R9 before power-down pair", int'(pair), 1);
    pwr_dn = 1'b1;
    wait_cyc(2);
    check("R9 power-down pair", int'(pair), 0);
    check("R9 power-down row", int'(row), 0);
    check("R9 power-down col", int'(col), 0);
    wait_cyc(2000);
    check("R9 held idle pair", int'(pair), 0);
    pwr_dn = 1'b0;
    wait_cyc(SETTLE);
    check("R9 resume pair", int'(pair), 1);
    check("R9 resume row", int'(row), 1);
    check("R9 resume col", int'(col), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule